// File: doc/BRIEF.md
# Multi-Mode Result Readout Port

This block is the parallel read side of a six-channel converter result store. A conversion engine writes 12-bit two's-complement results into it through a simple write port, and a host reads them back over a 16-bit bus. The bus is driven only while chip-select and the read strobe are both low; otherwise it is released to high impedance. Each word returned is self-describing: it carries a valid flag, a 3-bit channel code and the 12-bit result.

The 3-bit address/mode input chooses how a read is served. Codes for the six channels address a channel directly. One code selects a cycling pointer that steps through all six channels in a fixed order, one channel per completed read. Another code passes through the head word of an external first-in-first-out store and pulses a pop strobe once that word has been consumed. An independent byte-mode input splits each word into two 8-bit reads, low half first, so the port can sit on an 8-bit bus.

All control inputs are sampled on the block clock. A read completes when the read strobe rises while chip-select is still low; only a completed read moves the cycling pointer, the byte phase or the store's head.

Top module: `rdport_top`

## Requirements
- R1: The bus drive enable `busEn` is high exactly while `csN` and `rdN` are both low; at all other times the bus is released.
- R2: A word read in a direct or cycle read holds the valid flag in bit 15, the channel code in bits 14:12 and the 12-bit result in bits 11:0 (bit 11 is the sign bit).
- R3: Address/mode codes 0 to 5 return the channel with that code (0=A0, 1=A1, 2=B0, 3=B1, 4=C0, 5=C1), and a later write to a channel replaces its stored result.
- R4: A channel not written since reset reads back with bit 15 cleared, its own code in bits 14:12 and zero data.
- R5: With mode code 6 successive completed reads return channel codes 0,1,2,3,4,5 and then 0 again; the sequence starts at code 0 after reset, and direct reads do not move it.
- R6: A read whose chip-select rises before the read strobe does not advance the cycle pointer; the next completed cycle read returns the same channel.
- R7: With mode code 7 the bus carries `fifoHead` unchanged when `fifoEmpty` is low and all zeros when it is high; `fifoPop` pulses for one cycle after a completed read of a non-empty store, and never for an empty one.
- R8: With `byteMode` high the first read returns word bits 7:0 on bus bits 7:0 and the second returns word bits 15:8 on bus bits 7:0, bus bits 15:8 being zero; the cycle pointer and the pop strobe advance only after the second read.
- R9: Reset clears every stored result and valid flag, returns the cycle pointer to code 0 and the byte phase to the low half, and leaves the bus released.
- R10: A write whose channel code is 6 or 7 changes no stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip-select, active low |
| rdN | input | 1 | Read strobe, active low |
| addrMode | input | 3 | Channel code 0-5, 6 cycle mode, 7 store pass-through |
| byteMode | input | 1 | High selects two 8-bit reads per word |
| wrEn | input | 1 | Result write strobe from the conversion engine |
| wrChan | input | 3 | Channel code of the result written |
| wrData | input | 12 | Two's-complement result written |
| fifoHead | input | 16 | Head word of the external first-in-first-out store |
| fifoEmpty | input | 1 | High when the external store holds no word |
| fifoPop | output | 1 | One-cycle strobe removing the head word |
| busEn | output | 1 | High while the block drives the bus |
| busData | output | 16 | Read data, high impedance when not driven |

## Verification
The assertions assume that the read strobe and chip-select arrive already synchronous to the block clock, that `addrMode` and `byteMode` stay constant for the whole time the read strobe is low, and that `fifoEmpty` is steady around a read's completing edge. The bench drives every input on the falling clock edge, sets the mode together with the falling read strobe and only changes it after chip-select has been raised, so each read spans whole clock cycles and its completion lands on one known rising edge.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

  localparam int CHAN_W = 3;

  localparam logic [CHAN_W-1:0] MODE_CYCLE = 3'b110;
  localparam logic [CHAN_W-1:0] MODE_FIFO  = 3'b111;

  typedef enum logic [1:0] {
    LANE_FULL = 2'd0,
    LANE_LOW  = 2'd1,
    LANE_HIGH = 2'd2
  } lane_e;

  typedef struct packed {
    logic              busEn;
    logic              useFifo;
    logic [CHAN_W-1:0] selChan;
    lane_e             lane;
  } strobe_t;

endpackage

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
  import rdport_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic [CHAN_W-1:0] addrMode,
  input  logic              byteMode,
  input  logic              fifoEmpty,
  output strobe_t           strb,
  output logic              fifoPop
);

  localparam logic [CHAN_W-1:0] LAST_CH = CHAN_W'(NUM_CH - 1);

  logic              active;
  logic              complete;
  logic              lastPart;
  logic              advance;
  logic              prevActiveQ;
  logic [CHAN_W-1:0] modeQ;
  logic              byteQ;
  logic [CHAN_W-1:0] ptrQ;
  logic              phaseQ;

  // A read cycle is open while both strobes are low; it completes when the
  // read strobe rises with chip-select still held low.
  assign active   = !csN && !rdN;
  assign complete = prevActiveQ && rdN && !csN;
  assign lastPart = !byteQ || phaseQ;
  assign advance  = complete && lastPart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActiveQ <= 1'b0;
      modeQ       <= '0;
      byteQ       <= 1'b0;
      ptrQ        <= '0;
      phaseQ      <= 1'b0;
    end else begin
      prevActiveQ <= active;
      if (active) begin
        modeQ <= addrMode;
        byteQ <= byteMode;
      end
      if (complete) begin
        phaseQ <= byteQ && !phaseQ;
      end
      if (advance && (modeQ == MODE_CYCLE)) begin
        ptrQ <= (ptrQ == LAST_CH) ? '0 : ptrQ + 1'b1;
      end
    end
  end

  always_comb begin
    strb.busEn   = active;
    strb.useFifo = (addrMode == MODE_FIFO);
    strb.selChan = (addrMode == MODE_CYCLE) ? ptrQ : addrMode;
    if (!byteMode) begin
      strb.lane = LANE_FULL;
    end else if (phaseQ) begin
      strb.lane = LANE_HIGH;
    end else begin
      strb.lane = LANE_LOW;
    end
  end

  assign fifoPop = advance && (modeQ == MODE_FIFO) && !fifoEmpty;

  assert_ptr_range_R5 : assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= LAST_CH);

  assert_ptr_wrap_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (advance && (modeQ == MODE_CYCLE) && (ptrQ == LAST_CH)) |=> (ptrQ == '0));

  assert_abort_hold_R6 : assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ($stable(ptrQ) && $stable(phaseQ)));

  assert_pop_pulse_R7 : assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  assert_pop_on_rise_R7 : assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (!csN && rdN && !fifoEmpty));

endmodule

// File: rtl/rdport_dp.sv
module rdport_dp
  import rdport_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BUS_W-1:0]  fifoHead,
  input  logic              fifoEmpty,
  input  strobe_t           strb,
  output logic [BUS_W-1:0]  busWord
);

  localparam int HALF_W = BUS_W / 2;
  localparam int PAD_W  = BUS_W - 1 - CHAN_W - DATA_W;

  logic [NUM_CH-1:0] validQ;
  logic [DATA_W-1:0] dataQ [NUM_CH];
  logic [BUS_W-1:0]  fullWord;
  logic              selValid;
  logic [DATA_W-1:0] selData;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        dataQ[i]  <= '0;
      end else if (wrEn && (wrChan == CHAN_W'(i))) begin
        validQ[i] <= 1'b1;
        dataQ[i]  <= wrData;
      end
    end

    assert_valid_sticky_R2 : assert property (@(posedge clk) disable iff (!rstN)
      validQ[i] |=> validQ[i]);
  end

  always_comb begin
    selValid = 1'b0;
    selData  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (strb.selChan == CHAN_W'(i)) begin
        selValid = validQ[i];
        selData  = dataQ[i];
      end
    end
  end

  always_comb begin
    if (strb.useFifo) begin
      fullWord = fifoEmpty ? '0 : fifoHead;
    end else begin
      fullWord = {selValid, {PAD_W{1'b0}}, strb.selChan, selData};
    end
  end

  always_comb begin
    unique case (strb.lane)
      LANE_LOW:  busWord = {{(BUS_W-HALF_W){1'b0}}, fullWord[HALF_W-1:0]};
      LANE_HIGH: busWord = {{(BUS_W-HALF_W){1'b0}}, fullWord[BUS_W-1:HALF_W]};
      default:   busWord = fullWord;
    endcase
  end

  assert_bad_write_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrChan >= CHAN_W'(NUM_CH))) |=> $stable(validQ));

  assert_byte_upper_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.busEn && (strb.lane != LANE_FULL)) |-> (busWord[BUS_W-1:HALF_W] == '0));

endmodule

// File: rtl/rdport_top.sv
module rdport_top
  import rdport_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic [CHAN_W-1:0] addrMode,
  input  logic              byteMode,
  input  logic              wrEn,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BUS_W-1:0]  fifoHead,
  input  logic              fifoEmpty,
  output logic              fifoPop,
  output logic              busEn,
  output logic [BUS_W-1:0]  busData
);

  strobe_t          strb;
  logic [BUS_W-1:0] busWord;

  rdport_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdN       (rdN),
    .addrMode  (addrMode),
    .byteMode  (byteMode),
    .fifoEmpty (fifoEmpty),
    .strb      (strb),
    .fifoPop   (fifoPop)
  );

  rdport_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrChan    (wrChan),
    .wrData    (wrData),
    .fifoHead  (fifoHead),
    .fifoEmpty (fifoEmpty),
    .strb      (strb),
    .busWord   (busWord)
  );

  assign busEn   = strb.busEn;
  assign busData = strb.busEn ? busWord : {BUS_W{1'bz}};

  assert_drive_strobes_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> !busEn);

endmodule

// File: tb/rdport_top_tb.sv
module rdport_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 18;

  // Each entry: [19:17] address/mode, [16] byte mode, [15:0] expected bus word
  localparam logic [19:0] VECS [NUM_VEC] = '{
    20'h08123, 20'h29800, 20'h4A7FF, 20'h6BFFF, 20'h8C000, 20'hADA5C,
    20'hC8123, 20'hC9800, 20'hCA7FF, 20'hCBFFF, 20'hCC000, 20'hCDA5C,
    20'hC8123,
    20'h700FF, 20'h700BF,
    20'hD0000, 20'hD0098, 20'hCA7FF
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        rdN = 1'b1;
  logic [2:0]  addrMode = 3'd0;
  logic        byteMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrChan = 3'd0;
  logic [11:0] wrData = 12'd0;
  logic [15:0] fifoHead = 16'd0;
  logic        fifoEmpty = 1'b1;
  logic        fifoPop;
  logic        busEn;
  wire  [15:0] busData;

  int nVec = 0;
  int nFail = 0;
  int popCount = 0;

  rdport_top u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdN       (rdN),
    .addrMode  (addrMode),
    .byteMode  (byteMode),
    .wrEn      (wrEn),
    .wrChan    (wrChan),
    .wrData    (wrData),
    .fifoHead  (fifoHead),
    .fifoEmpty (fifoEmpty),
    .fifoPop   (fifoPop),
    .busEn     (busEn),
    .busData   (busData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (fifoPop) popCount++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [2:0] ch, input logic [11:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrChan = ch; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] m, input logic b, input logic [15:0] exp,
                        input string req, input bit abortIt);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addrMode = m; byteMode = b;
    #(CLK_PERIOD/4);
    check({req, " drive"}, {15'd0, busEn}, 16'd1);
    check(req, busData, exp);
    @(negedge clk);
    if (abortIt) begin
      csN = 1'b1;
      @(negedge clk);
      rdN = 1'b1;
    end else begin
      rdN = 1'b1;
      @(negedge clk);
      csN = 1'b1;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int popBefore;
    applyReset();

    // R1, R9: released bus after reset and while only one strobe is low
    #(CLK_PERIOD/4);
    check("R9 idle", {15'd0, busEn}, 16'd0);
    @(negedge clk); csN = 1'b0;
    #(CLK_PERIOD/4);
    check("R1 cs only", {15'd0, busEn}, 16'd0);
    @(negedge clk); csN = 1'b1; rdN = 1'b0;
    #(CLK_PERIOD/4);
    check("R1 rd only", {15'd0, busEn}, 16'd0);
    @(negedge clk); rdN = 1'b1;

    // R4: unwritten channels
    doRead(3'd2, 1'b0, 16'h2000, "R4 direct unwritten", 1'b0);
    doRead(3'd6, 1'b0, 16'h0000, "R4 R5 cycle start", 1'b0);

    // R9: reset returns the pointer to A0
    applyReset();
    doWrite(3'd0, 12'h123);
    doWrite(3'd1, 12'h800);
    doWrite(3'd2, 12'h7FF);
    doWrite(3'd3, 12'hFFF);
    doWrite(3'd4, 12'h000);
    doWrite(3'd5, 12'hA5C);
    doWrite(3'd6, 12'h111);
    doWrite(3'd7, 12'h222);

    // R2 R3 R5 R8 vector walk
    for (int k = 0; k < NUM_VEC; k++) begin
      doRead(VECS[k][19:17], VECS[k][16], VECS[k][15:0], "R2 R3 R5 R8 vector", 1'b0);
    end

    // R10: writes with codes 6 and 7 touched nothing
    doRead(3'd0, 1'b0, 16'h8123, "R10 ch0", 1'b0);
    doRead(3'd1, 1'b0, 16'h9800, "R10 ch1", 1'b0);

    // R6: aborted cycle read leaves the pointer on B1
    doRead(3'd6, 1'b0, 16'hBFFF, "R6 aborted", 1'b1);
    doRead(3'd6, 1'b0, 16'hBFFF, "R6 repeat", 1'b0);
    doRead(3'd6, 1'b0, 16'hC000, "R6 next", 1'b0);

    // R3: overwrite
    doWrite(3'd0, 12'h456);
    doRead(3'd0, 1'b0, 16'h8456, "R3 overwrite", 1'b0);

    // R7: store pass-through
    popBefore = popCount;
    fifoEmpty = 1'b1; fifoHead = 16'h5555;
    doRead(3'd7, 1'b0, 16'h0000, "R7 empty", 1'b0);
    check("R7 no pop when empty", 16'(popCount - popBefore), 16'd0);
    fifoEmpty = 1'b0; fifoHead = 16'h9ABC;
    doRead(3'd7, 1'b0, 16'h9ABC, "R7 head", 1'b0);
    check("R7 one pop", 16'(popCount - popBefore), 16'd1);

    // R8: byte split on the store
    fifoHead = 16'h1234;
    doRead(3'd7, 1'b1, 16'h0034, "R8 fifo low", 1'b0);
    check("R8 no pop after low", 16'(popCount - popBefore), 16'd1);
    doRead(3'd7, 1'b1, 16'h0012, "R8 fifo high", 1'b0);
    check("R8 pop after high", 16'(popCount - popBefore), 16'd2);
    fifoEmpty = 1'b1;

    // R9: reset clears stored results
    applyReset();
    doRead(3'd0, 1'b0, 16'h0000, "R9 cleared ch0", 1'b0);
    doRead(3'd5, 1'b0, 16'h5000, "R9 cleared ch5", 1'b0);
    doRead(3'd6, 1'b0, 16'h0000, "R9 pointer A0", 1'b0);

    summary();
    $finish;
  end

endmodule